// File: doc/BRIEF.md
# Programmable Bit-Mapping Pixel-to-Lane Mapper

The block takes one parallel RGB pixel with its horizontal sync, vertical sync and data-enable flags per clock. It turns each pixel into five 7-bit lane words for a 7:1 low-voltage differential transmitter. Every one of the 35 output bit slots has its own 5-bit source code. A code picks a colour bit, a sync or enable flag, one of two control bits, a toggling bit, or a constant. With these codes the same datapath can produce the common 24-bit layouts or any custom arrangement.

Pixels enter over a valid/ready stream. Lane words leave through a single registered valid/ready stage. A new pixel is accepted when the output register is empty or is being drained in the same cycle, so the stream runs at one pixel per clock while the sink keeps ready high. When the sink stalls, the registered word and its valid are held, and ready is withheld from the source.

The source codes are written through a plain write port into a shadow copy. They are applied to the datapath in one step by an apply strobe, so a word is never built from a mixture of two maps.

Top module: `lvds_bitmap_serializer`

## Requirements
- R1: `s_ready` is high exactly when the output holds no word or `m_ready` is high. A pixel is accepted when `s_valid` and `s_ready` are both high. Its lane word and `m_valid` appear on the next clock, so a continuous stream moves one pixel per clock.
- R2: While `m_valid` is high and `m_ready` is low, `m_valid` stays high, `m_lanes` does not change, and no pixel is accepted.
- R3: Source codes 0 to 7 select `s_rgb[0..7]` (red). Codes 8 to 15 select `s_rgb[8..15]` (green). Codes 16 to 23 select `s_rgb[16..23]` (blue). In each case the code value is the bit index into `s_rgb`.
- R4: Code 24 selects the internal HSYNC, code 25 the internal VSYNC and code 26 the internal DE. Code 27 selects `ctl_ce` and code 28 selects `ctl_ci`.
- R5: Code 29 selects a toggle bit. The toggle bit is 0 after reset and inverts after every accepted pixel.
- R6: Code 30 gives a constant 1 and code 31 gives a constant 0.
- R7: Bit b (0 to 6) of lane l (0 to 4) sits at `m_lanes[7*l + b]`.
- R8: The internal HSYNC, VSYNC and DE are `s_hs ^ pol_hs`, `s_vs ^ pol_vs` and `s_de ^ pol_de`. A polarity bit is set when its signal is active low.
- R9: A pixel accepted while `out_en` is low produces an all-zero lane word. The pixel is still accepted and the toggle bit still advances.
- R10: After reset the map is the standard layout. Each lane is listed from bit 6 down to bit 0. Lane 0: 1,1,0,0,0,1,1. Lane 1: G0,R5,R4,R3,R2,R1,R0. Lane 2: B1,B0,G5,G4,G3,G2,G1. Lane 3: DE,VS,HS,B5,B4,B3,B2. Lane 4: CE,B7,B6,G7,G6,R7,R6.
- R11: A write to address 2*l holds the codes of lane l bits 0..3 in `cfg_wdata` fields [4:0], [9:5], [14:10] and [19:15]. A write to address 2*l+1 holds bits 4..6 in fields [4:0], [9:5] and [14:10]. Writes to addresses 10 to 15 change nothing.
- R12: Writes change only the shadow map. A `cfg_apply` pulse in cycle t copies the shadow (as it was before any write in cycle t) into the active map. Pixels accepted from cycle t+1 on use the copied map, and pixels accepted up to cycle t use the previous one.
- R13: After reset `m_valid` is low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Pixel present |
| s_ready | output | 1 | Pixel accepted when high with `s_valid` |
| s_rgb | input | 24 | Red [7:0], green [15:8], blue [23:16] |
| s_hs | input | 1 | Horizontal sync pin level |
| s_vs | input | 1 | Vertical sync pin level |
| s_de | input | 1 | Data-enable pin level |
| m_valid | output | 1 | Lane word present |
| m_ready | input | 1 | Sink takes the lane word |
| m_lanes | output | 35 | Five 7-bit lane words, lane l at [7l+6:7l] |
| out_en | input | 1 | Output enable; low forces zero words |
| pol_hs | input | 1 | HSYNC active low |
| pol_vs | input | 1 | VSYNC active low |
| pol_de | input | 1 | DE active low |
| ctl_ce | input | 1 | Control bit for code 27 |
| ctl_ci | input | 1 | Control bit for code 28 |
| cfg_we | input | 1 | Map register write strobe |
| cfg_addr | input | 4 | Map register address |
| cfg_wdata | input | 20 | Map register data, four 5-bit fields |
| cfg_apply | input | 1 | Copy shadow map to active map |

## Verification
Assertions watch, on every cycle, that a stalled word and its valid are held. They also check that a pixel taken while disabled yields zeros, that the toggle bit inverts on each acceptance, that the active map stays still without an apply strobe, and that valid only rises after an offered pixel. The value of each mapped bit can only be shown by the bench scenarios. These scenarios cover the reset layout, custom maps that together use all 32 codes, the polarity combinations, ignored register addresses and the exact cycle at which an applied map takes over.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int CODE_W   = 5;
  localparam int NUM_SRC  = 1 << CODE_W;
  localparam int PIX_W    = 24;
  localparam int LO_SLOTS = 4;

  localparam logic [CODE_W-1:0] SRC_HS   = 5'h18;
  localparam logic [CODE_W-1:0] SRC_VS   = 5'h19;
  localparam logic [CODE_W-1:0] SRC_DE   = 5'h1A;
  localparam logic [CODE_W-1:0] SRC_CE   = 5'h1B;
  localparam logic [CODE_W-1:0] SRC_ONE  = 5'h1E;
  localparam logic [CODE_W-1:0] SRC_ZERO = 5'h1F;

  // Standard 24-bit layout used as the reset map.
  function automatic logic [CODE_W-1:0] std_code(input int lane, input int bpos);
    logic [CODE_W-1:0] c;
    c = SRC_ZERO;
    case (lane)
      0: c = (bpos >= 2 && bpos <= 4) ? SRC_ZERO : SRC_ONE;
      1: c = (bpos == 6) ? CODE_W'(8) : CODE_W'(bpos);
      2: c = (bpos == 6) ? CODE_W'(17) : (bpos == 5) ? CODE_W'(16) : CODE_W'(9 + bpos);
      3: c = (bpos == 6) ? SRC_DE : (bpos == 5) ? SRC_VS : (bpos == 4) ? SRC_HS
                                  : CODE_W'(18 + bpos);
      4: case (bpos)
           6: c = SRC_CE;
           5: c = CODE_W'(23);
           4: c = CODE_W'(22);
           3: c = CODE_W'(15);
           2: c = CODE_W'(14);
           1: c = CODE_W'(7);
           default: c = CODE_W'(6);
         endcase
      default: c = SRC_ZERO;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/lbs_map_regs.sv
module lbs_map_regs
  import lbs_pkg::*;
#(
  parameter int N_LANES   = 5,
  parameter int LANE_BITS = 7,
  parameter int ADDR_W    = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      cfg_we,
  input  logic [ADDR_W-1:0]                         cfg_addr,
  input  logic [LO_SLOTS*CODE_W-1:0]                cfg_wdata,
  input  logic                                      cfg_apply,
  output logic [N_LANES*LANE_BITS*CODE_W-1:0]       act_map
);
  localparam int SLOTS = N_LANES * LANE_BITS;

  logic [SLOTS*CODE_W-1:0] shadow_q;
  logic [SLOTS*CODE_W-1:0] active_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int LN  = s / LANE_BITS;
    localparam int BP  = s % LANE_BITS;
    localparam int HI  = (BP >= LO_SLOTS) ? 1 : 0;
    localparam int REG = 2 * LN + HI;
    localparam int FLD = (HI == 1) ? BP - LO_SLOTS : BP;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[s*CODE_W +: CODE_W] <= std_code(LN, BP);
        active_q[s*CODE_W +: CODE_W] <= std_code(LN, BP);
      end else begin
        if (cfg_we && cfg_addr == ADDR_W'(REG))
          shadow_q[s*CODE_W +: CODE_W] <= cfg_wdata[FLD*CODE_W +: CODE_W];
        if (cfg_apply)
          active_q[s*CODE_W +: CODE_W] <= shadow_q[s*CODE_W +: CODE_W];
      end
    end
  end

  assign act_map = active_q;

  // R12: the datapath map only moves on an apply strobe
  assert_map_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply |=> $stable(active_q));
endmodule

// File: rtl/lbs_bit_select.sv
module lbs_bit_select
  import lbs_pkg::*;
#(
  parameter int SLOTS = 35
) (
  input  logic [PIX_W-1:0]        rgb,
  input  logic                    hs_i,
  input  logic                    vs_i,
  input  logic                    de_i,
  input  logic                    ce_i,
  input  logic                    ci_i,
  input  logic                    tog_i,
  input  logic [SLOTS*CODE_W-1:0] map_i,
  output logic [SLOTS-1:0]        word_o
);
  logic [NUM_SRC-1:0] src;

  // index 31 .. 24 : zero, one, toggle, ci, ce, de, vs, hs ; 23..0 : colour
  assign src = {1'b0, 1'b1, tog_i, ci_i, ce_i, de_i, vs_i, hs_i, rgb};

  for (genvar s = 0; s < SLOTS; s++) begin : g_mux
    assign word_o[s] = src[map_i[s*CODE_W +: CODE_W]];
  end
endmodule

// File: rtl/lvds_bitmap_serializer.sv
module lvds_bitmap_serializer
  import lbs_pkg::*;
#(
  parameter int N_LANES   = 5,
  parameter int LANE_BITS = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              s_valid,
  output logic                              s_ready,
  input  logic [23:0]                       s_rgb,
  input  logic                              s_hs,
  input  logic                              s_vs,
  input  logic                              s_de,
  output logic                              m_valid,
  input  logic                              m_ready,
  output logic [N_LANES*LANE_BITS-1:0]      m_lanes,
  input  logic                              out_en,
  input  logic                              pol_hs,
  input  logic                              pol_vs,
  input  logic                              pol_de,
  input  logic                              ctl_ce,
  input  logic                              ctl_ci,
  input  logic                              cfg_we,
  input  logic [$clog2(2*N_LANES)-1:0]      cfg_addr,
  input  logic [19:0]                       cfg_wdata,
  input  logic                              cfg_apply
);
  localparam int SLOTS  = N_LANES * LANE_BITS;
  localparam int ADDR_W = $clog2(2 * N_LANES);

  logic [SLOTS*CODE_W-1:0] act_map;
  logic [SLOTS-1:0]        word;
  logic                    tog_q;
  logic                    valid_q;
  logic [SLOTS-1:0]        lanes_q;
  logic                    take;

  assign s_ready = !valid_q || m_ready;
  assign take    = s_valid && s_ready;

  lbs_map_regs #(.N_LANES(N_LANES), .LANE_BITS(LANE_BITS), .ADDR_W(ADDR_W)) map_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_apply (cfg_apply),
    .act_map   (act_map)
  );

  lbs_bit_select #(.SLOTS(SLOTS)) sel_i (
    .rgb    (s_rgb),
    .hs_i   (s_hs ^ pol_hs),
    .vs_i   (s_vs ^ pol_vs),
    .de_i   (s_de ^ pol_de),
    .ce_i   (ctl_ce),
    .ci_i   (ctl_ci),
    .tog_i  (tog_q),
    .map_i  (act_map),
    .word_o (word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      valid_q <= 1'b0;
      lanes_q <= '0;
    end else begin
      if (s_ready) valid_q <= s_valid;
      if (take) begin
        tog_q   <= ~tog_q;
        lanes_q <= out_en ? word : '0;
      end
    end
  end

  assign m_valid = valid_q;
  assign m_lanes = lanes_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_lanes));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && !out_en |=> m_valid && (m_lanes == '0));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> tog_q != $past(tog_q));

  assert_valid_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid));
endmodule

// File: tb/lvds_bitmap_serializer_tb_top.sv
`timescale 1ns/1ps
module lvds_bitmap_serializer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, m_ready = 0, s_hs = 0, s_vs = 0, s_de = 0;
  logic [23:0] s_rgb = '0;
  logic out_en = 0, pol_hs = 0, pol_vs = 0, pol_de = 0, ctl_ce = 0, ctl_ci = 0;
  logic cfg_we = 0, cfg_apply = 0;
  logic [3:0] cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic s_ready, m_valid;
  logic [34:0] m_lanes;

  always #5 clk = ~clk;

  lvds_bitmap_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_rgb(s_rgb),
    .s_hs(s_hs), .s_vs(s_vs), .s_de(s_de), .m_valid(m_valid), .m_ready(m_ready),
    .m_lanes(m_lanes), .out_en(out_en), .pol_hs(pol_hs), .pol_vs(pol_vs),
    .pol_de(pol_de), .ctl_ce(ctl_ce), .ctl_ci(ctl_ci), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_apply(cfg_apply)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string cur_req = "R13";
  bit done = 0;

  // behavioural reference model
  int shadow[5][7];
  int active[5][7];
  bit exp_valid;
  logic [34:0] exp_word;
  bit tog;

  function automatic void std_layout(ref int m[5][7]);
    int l1[7] = '{0, 1, 2, 3, 4, 5, 8};
    int l2[7] = '{9, 10, 11, 12, 13, 16, 17};
    int l3[7] = '{18, 19, 20, 21, 24, 25, 26};
    int l4[7] = '{6, 7, 14, 15, 22, 23, 27};
    int l0[7] = '{30, 30, 31, 31, 31, 30, 30};
    for (int b = 0; b < 7; b++) begin
      m[0][b] = l0[b]; m[1][b] = l1[b]; m[2][b] = l2[b];
      m[3][b] = l3[b]; m[4][b] = l4[b];
    end
  endfunction

  function automatic bit pick(int code);
    if (code < 24) return s_rgb[code];
    case (code)
      24: return s_hs ^ pol_hs;
      25: return s_vs ^ pol_vs;
      26: return s_de ^ pol_de;
      27: return ctl_ce;
      28: return ctl_ci;
      29: return tog;
      30: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit rdy;
    logic [34:0] w;
    if (!rst_n) begin
      std_layout(shadow);
      std_layout(active);
      exp_valid = 0; exp_word = '0; tog = 0;
    end else begin
      rdy = !exp_valid || m_ready;
      if (rdy) begin
        if (s_valid) begin
          for (int l = 0; l < 5; l++)
            for (int b = 0; b < 7; b++) w[7*l+b] = pick(active[l][b]);
          exp_word = out_en ? w : '0;
          tog = !tog;
        end
        exp_valid = s_valid;
      end
      if (cfg_apply) active = shadow;
      if (cfg_we && cfg_addr < 10) begin
        if (cfg_addr[0] == 0)
          for (int f = 0; f < 4; f++) shadow[cfg_addr/2][f] = int'(cfg_wdata[5*f +: 5]);
        else
          for (int f = 0; f < 3; f++) shadow[cfg_addr/2][4+f] = int'(cfg_wdata[5*f +: 5]);
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      chk({cur_req, " R1 ready"}, 64'(s_ready), 64'(!exp_valid || m_ready));
      chk({cur_req, " R1 valid"}, 64'(m_valid), 64'(exp_valid));
      if (exp_valid) chk({cur_req, " R7 lanes"}, 64'(m_lanes), 64'(exp_word));
    end
  end

  function automatic int cmap(int l, int b, int k);
    return (7*l + b + k) % 32;
  endfunction

  task automatic write_map(input int k);
    for (int l = 0; l < 5; l++) begin
      @(negedge clk);
      cfg_we = 1; cfg_addr = 4'(2*l);
      cfg_wdata = {5'(cmap(l,3,k)), 5'(cmap(l,2,k)), 5'(cmap(l,1,k)), 5'(cmap(l,0,k))};
      @(negedge clk);
      cfg_addr = 4'(2*l+1);
      cfg_wdata = {5'd0, 5'(cmap(l,6,k)), 5'(cmap(l,5,k)), 5'(cmap(l,4,k))};
    end
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic stream(input int n, input int seed, input bit stall);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1;
      s_rgb   = 24'((i + seed) * 32'h9E3779B1 >> 5);
      s_hs    = ((i + seed) % 3) == 0;
      s_vs    = ((i + seed) % 5) == 1;
      s_de    = ((i + seed) % 2) == 0;
      ctl_ce  = ((i + seed) % 7) < 3;
      ctl_ci  = ((i + seed) % 4) == 2;
      m_ready = stall ? (((i * 3 + seed) % 5) < 2) : 1'b1;
    end
    @(negedge clk); s_valid = 0; m_ready = 1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13 reset valid", 64'(m_valid), 64'd0);
    chk("R13 reset ready", 64'(s_ready), 64'd1);

    // R10: reset layout, directed look at clock lane and lane 1 bit 6
    cur_req = "R10"; out_en = 1; m_ready = 1;
    s_valid = 1; s_rgb = 24'h00_01_00; s_de = 1;
    @(negedge clk); s_valid = 0;
    chk("R10 clock lane", 64'(m_lanes[6:0]), 64'(7'b1100011));
    chk("R10 lane1 bit6 G0", 64'(m_lanes[13]), 64'd1);
    chk("R10 lane3 bit6 DE", 64'(m_lanes[27]), 64'd1);
    stream(40, 1, 0);

    // R1 throughput / R2 stalls
    cur_req = "R2 stall";
    stream(60, 7, 1);

    // R8 polarity combinations
    cur_req = "R8 polarity";
    pol_hs = 1; stream(10, 3, 0);
    pol_vs = 1; pol_de = 1; stream(10, 4, 0);
    pol_hs = 0; stream(10, 5, 0);
    pol_vs = 0; pol_de = 0;

    // R9 disabled output
    cur_req = "R9 disabled";
    out_en = 0;
    @(negedge clk); s_valid = 1; s_rgb = 24'hFFFFFF; m_ready = 1;
    @(negedge clk); s_valid = 0;
    chk("R9 zero word", 64'(m_lanes), 64'd0);
    stream(10, 9, 1);
    out_en = 1;

    // R12: write without apply has no effect
    cur_req = "R12 no apply";
    write_map(0);
    stream(12, 11, 0);
    @(negedge clk); cfg_apply = 1; s_valid = 1; s_rgb = 24'h123456;
    @(negedge clk); cfg_apply = 0;
    cur_req = "R12 applied";
    @(negedge clk); s_valid = 0;
    // R3 R4 R5 R6 R11: custom maps cover all 32 codes
    cur_req = "R3/R4/R5/R6/R11 map k0";
    stream(40, 13, 1);
    write_map(9);
    // R11: addresses 10..15 ignored
    for (int a = 10; a < 16; a++) begin
      @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = 20'hFFFFF;
    end
    @(negedge clk); cfg_we = 0; cfg_apply = 1;
    @(negedge clk); cfg_apply = 0;
    cur_req = "R3/R4/R5/R6/R11 map k9";
    stream(40, 21, 1);

    // R5: toggle on a known slot (lane 0 bit 0 = code 29)
    cur_req = "R5 toggle";
    write_map(29);
    @(negedge clk); cfg_apply = 1;
    @(negedge clk); cfg_apply = 0;
    stream(16, 2, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule